// File: doc/BRIEF.md
# Receive destination MAC address filter

This block inspects the destination MAC address of each received Ethernet frame and decides whether the frame is kept or dropped. Software fills a small table of unicast addresses, each entry with its own enable flag, and selects one of four checking policies. For every frame the block reports whether the address hit the table and which entry hit, and it flags broadcast and multicast destinations.

The keep/drop verdict combines the address policy with the frame's error flags and an external drop request from upstream logic. The lookup and the verdict are registered: a frame presented with its address strobe gets its results, with a one-cycle result strobe, on the following clock.

Top module: `dmac_filter`

## Requirements
- R1: After reset every table entry is disabled and the policy is 0; all outputs are low and a lookup without errors reports no hit and no drop.
- R2: `res_vld` pulses high exactly one clock after each cycle with `dst_vld` high and is low otherwise; all other outputs hold their last value between lookups.
- R3: A write with `cfg_addr` below 16 loads entry `cfg_addr` with enable `cfg_wdata[48]` and address `cfg_wdata[47:0]`; only enabled entries can produce a hit.
- R4: When several enabled entries equal the destination, `hit_idx` reports the lowest-numbered one and `hit_vld` is high.
- R5: When no enabled entry matches, `hit_vld` is low and `hit_idx` is 0.
- R6: A destination of all ones sets `is_bcast`.
- R7: `is_mcast` is set when destination bit 40 is 1 and the destination is not all ones.
- R8: A write with `cfg_addr` equal to 16 loads the policy from `cfg_wdata[1:0]`; policy 0 never drops on address grounds.
- R9: Policy 1 drops every frame without a hit.
- R10: Policy 2 drops a frame only when it has no hit and is not broadcast.
- R11: Policy 3 drops a frame only when it has no hit and is not multicast.
- R12: `drop` is also set when `drop_req` is high or any bit of `err_flags` is high (bit 0 framing, 1 runt, 2 oversize, 3 CRC, 4 MAC error).
- R13: A write in the same cycle as a lookup does not affect that lookup; the next lookup sees it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dst_addr | input | 48 | Destination MAC address of the frame |
| dst_vld | input | 1 | Address strobe, one cycle per frame |
| err_flags | input | 5 | Frame error flags, sampled with `dst_vld` |
| drop_req | input | 1 | External drop request, sampled with `dst_vld` |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Write target: 0 to 15 table entry, 16 policy |
| cfg_wdata | input | 49 | Write data: enable and address, or policy in bits 1:0 |
| res_vld | output | 1 | Result strobe |
| hit_vld | output | 1 | Destination matched an enabled entry |
| hit_idx | output | 4 | Lowest matching entry, 0 when no hit |
| is_bcast | output | 1 | Destination is broadcast |
| is_mcast | output | 1 | Destination is multicast |
| drop | output | 1 | Frame is to be dropped |

## Verification
Every result of the block (hit, index, broadcast, multicast, drop) is due on the clock edge after the address strobe, together with `res_vld`, and holds until the next strobe. The bench drives inputs on the falling edge, computes the expected outputs from its own table model using the state before any same-cycle write, and compares all outputs on the next falling edge, once per clock. Writes coinciding with lookups, duplicate entries, disabled entries with matching addresses and each error flag are placed so the one-cycle latency and the pre-write ordering are both tested.

// File: rtl/dmac_filter.sv
module dmac_filter #(
  parameter int ENTRIES = 16,
  parameter int AW      = 48,
  parameter int MCBIT   = 40,
  parameter int NERR    = 5,
  localparam int IW     = $clog2(ENTRIES),
  localparam int CW     = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dst_addr,
  input  logic          dst_vld,
  input  logic [NERR-1:0] err_flags,
  input  logic          drop_req,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_addr,
  input  logic [AW:0]   cfg_wdata,
  output logic          res_vld,
  output logic          hit_vld,
  output logic [IW-1:0] hit_idx,
  output logic          is_bcast,
  output logic          is_mcast,
  output logic          drop
);

  logic [ENTRIES-1:0] ent_on;
  logic [AW-1:0]      ent_addr [ENTRIES];
  logic [1:0]         mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_on <= '0;
      mode   <= 2'd0;
      for (int i = 0; i < ENTRIES; i++) ent_addr[i] <= '0;
    end else if (cfg_we) begin
      if (cfg_addr < CW'(ENTRIES)) begin
        ent_on[cfg_addr[IW-1:0]]   <= cfg_wdata[AW];
        ent_addr[cfg_addr[IW-1:0]] <= cfg_wdata[AW-1:0];
      end else if (cfg_addr == CW'(ENTRIES)) begin
        mode <= cfg_wdata[1:0];
      end
    end
  end

  logic [ENTRIES-1:0] match;
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_on[g] && (ent_addr[g] == dst_addr);
  end

  logic [IW-1:0] first;
  always_comb begin
    first = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) first = IW'(i);
  end

  wire found = |match;
  wire bc    = &dst_addr;
  wire mc    = dst_addr[MCBIT] & ~bc;

  logic pol_drop;
  always_comb begin
    case (mode)
      2'd1:    pol_drop = ~found;
      2'd2:    pol_drop = ~(found | bc);
      2'd3:    pol_drop = ~(found | mc);
      default: pol_drop = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld  <= 1'b0;
      hit_vld  <= 1'b0;
      hit_idx  <= '0;
      is_bcast <= 1'b0;
      is_mcast <= 1'b0;
      drop     <= 1'b0;
    end else begin
      res_vld <= dst_vld;
      if (dst_vld) begin
        hit_vld  <= found;
        hit_idx  <= found ? first : '0;
        is_bcast <= bc;
        is_mcast <= mc;
        drop     <= pol_drop | drop_req | (|err_flags);
      end
    end
  end

endmodule

// File: rtl/dmac_filter_chk.sv
module dmac_filter_chk #(
  parameter int AW    = 48,
  parameter int MCBIT = 40,
  parameter int NERR  = 5,
  parameter int IW    = 4,
  parameter int CW    = 5,
  parameter int ENTRIES = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] dst_addr,
  input logic          dst_vld,
  input logic [NERR-1:0] err_flags,
  input logic          drop_req,
  input logic          cfg_we,
  input logic [CW-1:0] cfg_addr,
  input logic [1:0]    mode_wdata,
  input logic          res_vld,
  input logic          hit_vld,
  input logic [IW-1:0] hit_idx,
  input logic          is_bcast,
  input logic          is_mcast,
  input logic          drop
);

  logic [1:0] mode_sh;
  always_ff @(posedge clk) begin
    if (!rst_n) mode_sh <= 2'd0;
    else if (cfg_we && cfg_addr == CW'(ENTRIES)) mode_sh <= mode_wdata;
  end

  AST_RES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dst_vld |=> res_vld); // R2
  AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_vld |=> !res_vld); // R2
  AST_IDX_ZERO_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_vld |-> hit_idx == '0); // R5
  AST_BCAST_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_vld && &dst_addr) |=> is_bcast); // R6
  AST_MCAST_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_vld && dst_addr[MCBIT] && !(&dst_addr)) |=> (is_mcast && !is_bcast)); // R7
  AST_ERR_FORCES_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_vld && (drop_req || |err_flags)) |=> drop); // R12
  AST_STRICT_MISS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_vld && mode_sh == 2'd1) |=> (hit_vld || drop)); // R9

endmodule

bind dmac_filter dmac_filter_chk #(
  .AW(AW), .MCBIT(MCBIT), .NERR(NERR), .IW(IW), .CW(CW), .ENTRIES(ENTRIES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .dst_addr(dst_addr), .dst_vld(dst_vld),
  .err_flags(err_flags), .drop_req(drop_req), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .mode_wdata(cfg_wdata[1:0]), .res_vld(res_vld),
  .hit_vld(hit_vld), .hit_idx(hit_idx), .is_bcast(is_bcast),
  .is_mcast(is_mcast), .drop(drop)
);

// File: tb/dmac_filter_tb.sv
module dmac_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [47:0] dst_addr = '0;
  logic dst_vld = 1'b0;
  logic [4:0] err_flags = '0;
  logic drop_req = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [48:0] cfg_wdata = '0;
  logic res_vld, hit_vld, is_bcast, is_mcast, drop;
  logic [3:0] hit_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_filter dut_i (.*);

  int vectors = 0;
  int miscompares = 0;

  bit          m_on   [16];
  logic [47:0] m_addr [16];
  int          m_mode;
  logic e_res, e_hit, e_bc, e_mc, e_drop;
  logic [3:0] e_idx;

  task automatic chk(string req, string what, logic [47:0] act, logic [47:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_on[i] = 0; m_addr[i] = '0; end
    m_mode = 0;
    e_res = 0; e_hit = 0; e_idx = 0; e_bc = 0; e_mc = 0; e_drop = 0;
  endtask

  task automatic compare_all(string tag);
    vectors++;
    chk({tag, "/R2"}, "res_vld", 48'(res_vld), 48'(e_res));
    chk({tag, "/R4"}, "hit_vld", 48'(hit_vld), 48'(e_hit));
    chk({tag, "/R5"}, "hit_idx", 48'(hit_idx), 48'(e_idx));
    chk({tag, "/R6"}, "is_bcast", 48'(is_bcast), 48'(e_bc));
    chk({tag, "/R7"}, "is_mcast", 48'(is_mcast), 48'(e_mc));
    chk({tag, "/R12"}, "drop", 48'(drop), 48'(e_drop));
  endtask

  // one clock: drive at falling edge, predict from pre-write model, compare next falling edge
  task automatic step(string tag, logic v, logic [47:0] a, logic [4:0] e, logic dr,
                      logic we, logic [4:0] wa, logic [48:0] wd);
    bit hit, bc, mc, pd;
    int idx;
    dst_vld = v; dst_addr = a; err_flags = e; drop_req = dr;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    e_res = v;
    if (v) begin
      hit = 0; idx = 0;
      for (int i = 0; i < 16; i++)
        if (!hit && m_on[i] && m_addr[i] == a) begin hit = 1; idx = i; end
      bc = (a == BC);
      mc = a[40] && !bc;
      case (m_mode)
        1: pd = !hit;
        2: pd = !(hit || bc);
        3: pd = !(hit || mc);
        default: pd = 0;
      endcase
      e_hit = hit; e_idx = 4'(idx); e_bc = bc; e_mc = mc;
      e_drop = pd || dr || (e != 0);
    end
    if (we) begin
      if (wa < 16) begin m_on[wa] = wd[48]; m_addr[wa] = wd[47:0]; end
      else if (wa == 16) m_mode = int'(wd[1:0]);
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic look(string tag, logic [47:0] a, logic [4:0] e = 0, logic dr = 0);
    step(tag, 1, a, e, dr, 0, 0, '0);
  endtask

  task automatic wr(string tag, logic [4:0] wa, logic [48:0] wd);
    step(tag, 0, '0, 0, 0, 1, wa, wd);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R1 after reset");
    look("R1 empty table", 48'h0000_1122_3344);
    look("R1 empty table addr0", 48'h0);
    step("R2 idle", 0, 48'h1, 0, 0, 0, 0, '0);

    wr("R3 load e3", 5'd3, {1'b1, 48'h0200_0000_0003});
    wr("R3 load e7 disabled", 5'd7, {1'b0, 48'h0200_0000_0007});
    look("R3 hit e3", 48'h0200_0000_0003);
    look("R3 disabled e7", 48'h0200_0000_0007);
    wr("R4 dup e9", 5'd9, {1'b1, 48'h0200_0000_0003});
    wr("R4 dup e1", 5'd1, {1'b1, 48'h0200_0000_0003});
    look("R4 lowest wins", 48'h0200_0000_0003);
    wr("R4 drop e1", 5'd1, {1'b0, 48'h0200_0000_0003});
    look("R4 next lowest", 48'h0200_0000_0003);
    wr("R3 e15", 5'd15, {1'b1, 48'hABCD_EF01_2345});
    look("R3 top entry", 48'hABCD_EF01_2345);
    look("R5 miss", 48'h0200_0000_0099);
    look("R6 bcast", BC);
    look("R7 mcast", 48'h0100_5E00_0001);
    look("R7 no mcast", 48'hFEFF_FFFF_FFFF);

    for (int m = 0; m < 4; m++) begin
      wr("R8 set policy", 5'd16, 49'(m));
      look("R8 R9 R10 R11 hit", 48'h0200_0000_0003);
      look("R8 R9 R10 R11 miss", 48'h0200_0000_0055);
      look("R8 R9 R10 R11 bcast", BC);
      look("R8 R9 R10 R11 mcast", 48'h0100_5E00_00FB);
    end
    wr("R8 policy 0", 5'd16, 49'd0);
    for (int b = 0; b < 5; b++) look("R12 err bit", 48'h0200_0000_0003, 5'(1 << b));
    look("R12 drop_req", 48'h0200_0000_0003, 0, 1);

    step("R13 write during lookup", 1, 48'h0200_0000_0055, 0, 0, 1, 5'd0, {1'b1, 48'h0200_0000_0055});
    look("R13 next lookup", 48'h0200_0000_0055);
    step("R13 policy during lookup", 1, 48'h0200_0000_0066, 0, 0, 1, 5'd16, 49'd1);
    look("R13 policy next", 48'h0200_0000_0066);
    step("R3 addr 17 no effect", 0, '0, 0, 0, 1, 5'd17, 49'd0);
    look("R9 policy kept", 48'h0200_0000_0066);

    for (int n = 0; n < 3000; n++) begin
      int k = $urandom_range(0, 9);
      logic [47:0] a;
      if (k < 5) a = {40'h02_0000_0000, 8'($urandom_range(0, 15))};
      else if (k == 5) a = BC;
      else if (k == 6) a = {8'h01, 8'h00, 32'($urandom)};
      else a = {16'($urandom), 32'($urandom)};
      step("R2 R4 R9 R12 random", 1'($urandom_range(0, 3) != 0), a,
           ($urandom_range(0, 7) == 0) ? 5'($urandom) : 5'd0,
           $urandom_range(0, 15) == 0,
           $urandom_range(0, 4) == 0, 5'($urandom_range(0, 17)),
           {1'($urandom), 40'h02_0000_0000, 8'($urandom_range(0, 15))});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule